// File: doc/BRIEF.md
# SPI Host Interrupt Aggregator

This block collects the error and event conditions of a SPI host controller and turns them into two level-sensitive interrupt lines. One line is for errors and one is for events. The transfer engine reports errors as single-cycle pulses. These pulses are held in a sticky error-status register until software clears them. Events come in as live status levels and are sampled every cycle.

A small register file sits on a simple write/read port. It holds the interrupt state, the interrupt enable, the interrupt test, the per-cause error enable, the error status and the per-condition event enable. An enabled cause sets the matching interrupt-state bit. That bit stays set until software writes a one to it. The line itself is the state bit gated by its enable.

A write to the test register forces either state bit for diagnostic purposes. The block does no shifting and has no FIFOs.

Top module: `spih_irq_hub`

## Requirements
- R1: After reset, the registers read as follows: interrupt state 0, interrupt enable 0, test 0, error enable 0x1F, error status 0, event enable 0. Both interrupt outputs are low.
- R2: A one-cycle pulse on `err_pulse[i]` sets error-status bit i at the clock edge that samples it. The pulse order is bit 0 command-while-busy, bit 1 overflow, bit 2 underflow, bit 3 invalid command, bit 4 invalid chip select, bit 5 invalid access. The bit stays set after the pulse ends. A pulse wins over a clear in the same cycle.
- R3: Error status (word address 4) is write-one-to-clear. A one in a data bit clears that bit, and a zero leaves it unchanged.
- R4: Error enable (word address 3) holds one enable bit for each of error bits 0 to 4. Suppose interrupt-enable bit 0 is set and some error-status bit is set together with its enable. Then interrupt-state bit 0 becomes set one edge after the status bit is set. A cause whose enable is clear does not set it.
- R5: Error-status bit 5 (invalid access) has no enable bit. It never sets the error interrupt.
- R6: Event enable (word address 5) bits are 0 RX full, 1 TX empty, 2 RX watermark, 3 TX watermark, 4 ready, 5 idle. The `evt_level` input uses the same order. Suppose interrupt-enable bit 1 is set and an input level on bit 0, 1 or 4 is high with its enable set. Then interrupt-state bit 1 is set at the next edge. Bits 2, 3 and 5 never set it, even when enabled.
- R7: Writing a one to bit 0 or bit 1 of the test register (word address 2) sets the matching interrupt-state bit at that write's edge, if that interrupt is enabled. If the interrupt is not enabled, the write has no effect. The test register always reads 0.
- R8: Interrupt state (word address 0) has bit 0 for error and bit 1 for event, and is write-one-to-clear. A clear is overridden while a set condition is active in the same cycle. A state bit stays set until it is cleared.
- R9: `irq_err` is interrupt-state bit 0 AND interrupt-enable bit 0, and `irq_evt` is state bit 1 AND enable bit 1 (word address 1, same layout). Clearing an enable bit drops its line but keeps the state bit. Setting the enable again raises the line again.
- R10: Reads return each register zero-extended to the data width. Word addresses 6 and 7 read 0. Writes to those addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| err_pulse | input | 6 | One-cycle error cause pulses |
| evt_level | input | 6 | Live event condition levels |
| irq_err | output | 1 | Error interrupt line |
| irq_evt | output | 1 | Event interrupt line |

## Verification
The error path is driven with single pulses on different cause bits. It is also driven with the enable mask both including and excluding the pulsed cause, and with the unmaskable access bit. Together these separate the sticky latching from the enable gating. The event path is driven with each triggering level and with the watermark and idle levels, all enabled, to show which conditions can raise the line. Same-cycle pulse-and-clear and clear-while-cause-active patterns show the set-over-clear priority. Toggling the enable around a set state bit separates line gating from state storage.

// File: rtl/spih_irq_pkg.sv
`timescale 1ns/1ps
package spih_irq_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_STATE    = 3'd0,
    RA_ENABLE   = 3'd1,
    RA_TEST     = 3'd2,
    RA_ERR_EN   = 3'd3,
    RA_ERR_STAT = 3'd4,
    RA_EVT_EN   = 3'd5
  } reg_addr_e;

  localparam int IRQ_ERR_BIT = 0;
  localparam int IRQ_EVT_BIT = 1;
  localparam int N_IRQ       = 2;
endpackage

// File: rtl/spih_rst_sync.sv
`timescale 1ns/1ps
module spih_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/spih_en_reg.sv
`timescale 1ns/1ps
module spih_en_reg #(
  parameter int           W   = 2,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;

  always_comb q_nxt = d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= RST;
    else if (we) q_r <= q_nxt;
  end

  assign q = q_r;
endmodule

// File: rtl/spih_w1c_bank.sv
`timescale 1ns/1ps
module spih_w1c_bank #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic bit_q;
    logic bit_nxt;
    logic bit_en;

    always_comb begin
      bit_en  = set_i[i] | clr_i[i];
      bit_nxt = set_i[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bit_q <= 1'b0;
      else if (bit_en) bit_q <= bit_nxt;
    end

    assign q_o[i] = bit_q;
  end
endmodule

// File: rtl/spih_cause_reduce.sv
`timescale 1ns/1ps
module spih_cause_reduce #(
  parameter int W = 5
) (
  input  logic [W-1:0] level_i,
  input  logic [W-1:0] mask_i,
  output logic         hit_o
);
  always_comb hit_o = |(level_i & mask_i);
endmodule

// File: rtl/spih_irq_hub.sv
`timescale 1ns/1ps
module spih_irq_hub
  import spih_irq_pkg::*;
#(
  parameter int              DATA_W       = 32,
  parameter int              N_ERR        = 6,
  parameter int              N_ERR_EN     = 5,
  parameter int              N_EVT        = 6,
  parameter logic [N_EVT-1:0] EVT_IRQ_MASK = 6'b01_0011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [N_ERR-1:0]  err_pulse,
  input  logic [N_EVT-1:0]  evt_level,
  output logic              irq_err,
  output logic              irq_evt
);
  localparam logic [N_ERR_EN-1:0] ERR_EN_RST = {N_ERR_EN{1'b1}};

  logic                rst_sync_n;
  logic                wr_state, wr_enable, wr_test, wr_err_en, wr_err_stat, wr_evt_en;
  logic [N_IRQ-1:0]    irq_en_q;
  logic [N_ERR_EN-1:0] err_en_q;
  logic [N_EVT-1:0]    evt_en_q;
  logic [N_ERR-1:0]    err_status_q;
  logic [N_IRQ-1:0]    irq_state_q;
  logic [N_ERR-1:0]    err_clr;
  logic [N_IRQ-1:0]    irq_clr;
  logic [N_IRQ-1:0]    irq_set;
  logic [N_IRQ-1:0]    test_pulse;
  logic [N_EVT-1:0]    evt_mask_eff;
  logic                err_hit;
  logic                evt_hit;
  logic                unused_wdata_hi;

  spih_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    wr_state    = wr_en && (addr == RA_STATE);
    wr_enable   = wr_en && (addr == RA_ENABLE);
    wr_test     = wr_en && (addr == RA_TEST);
    wr_err_en   = wr_en && (addr == RA_ERR_EN);
    wr_err_stat = wr_en && (addr == RA_ERR_STAT);
    wr_evt_en   = wr_en && (addr == RA_EVT_EN);
  end

  assign unused_wdata_hi = ^wdata[DATA_W-1:N_ERR];

  spih_en_reg #(.W(N_IRQ), .RST('0)) u_irq_en (
    .clk (clk), .rst_n (rst_sync_n), .we (wr_enable),
    .d   (wdata[N_IRQ-1:0]), .q (irq_en_q)
  );

  spih_en_reg #(.W(N_ERR_EN), .RST(ERR_EN_RST)) u_err_en (
    .clk (clk), .rst_n (rst_sync_n), .we (wr_err_en),
    .d   (wdata[N_ERR_EN-1:0]), .q (err_en_q)
  );

  spih_en_reg #(.W(N_EVT), .RST('0)) u_evt_en (
    .clk (clk), .rst_n (rst_sync_n), .we (wr_evt_en),
    .d   (wdata[N_EVT-1:0]), .q (evt_en_q)
  );

  always_comb err_clr = wr_err_stat ? wdata[N_ERR-1:0] : '0;

  spih_w1c_bank #(.W(N_ERR)) u_err_status (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set_i (err_pulse),
    .clr_i (err_clr),
    .q_o   (err_status_q)
  );

  spih_cause_reduce #(.W(N_ERR_EN)) u_err_reduce (
    .level_i (err_status_q[N_ERR_EN-1:0]),
    .mask_i  (err_en_q),
    .hit_o   (err_hit)
  );

  always_comb evt_mask_eff = evt_en_q & EVT_IRQ_MASK;

  spih_cause_reduce #(.W(N_EVT)) u_evt_reduce (
    .level_i (evt_level),
    .mask_i  (evt_mask_eff),
    .hit_o   (evt_hit)
  );

  always_comb begin
    test_pulse           = wr_test  ? wdata[N_IRQ-1:0] : '0;
    irq_clr              = wr_state ? wdata[N_IRQ-1:0] : '0;
    irq_set[IRQ_ERR_BIT] = irq_en_q[IRQ_ERR_BIT] & (test_pulse[IRQ_ERR_BIT] | err_hit);
    irq_set[IRQ_EVT_BIT] = irq_en_q[IRQ_EVT_BIT] & (test_pulse[IRQ_EVT_BIT] | evt_hit);
  end

  spih_w1c_bank #(.W(N_IRQ)) u_irq_state (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set_i (irq_set),
    .clr_i (irq_clr),
    .q_o   (irq_state_q)
  );

  assign irq_err = irq_state_q[IRQ_ERR_BIT] & irq_en_q[IRQ_ERR_BIT];
  assign irq_evt = irq_state_q[IRQ_EVT_BIT] & irq_en_q[IRQ_EVT_BIT];

  always_comb begin
    rdata = '0;
    case (addr)
      RA_STATE:    rdata[N_IRQ-1:0]    = irq_state_q;
      RA_ENABLE:   rdata[N_IRQ-1:0]    = irq_en_q;
      RA_ERR_EN:   rdata[N_ERR_EN-1:0] = err_en_q;
      RA_ERR_STAT: rdata[N_ERR-1:0]    = err_status_q;
      RA_EVT_EN:   rdata[N_EVT-1:0]    = evt_en_q;
      default:     rdata               = '0;
    endcase
  end
endmodule

// File: rtl/spih_irq_hub_chk.sv
`timescale 1ns/1ps
module spih_irq_hub_chk
  import spih_irq_pkg::*;
#(
  parameter int               DATA_W       = 32,
  parameter int               N_ERR        = 6,
  parameter int               N_EVT        = 6,
  parameter logic [N_EVT-1:0] EVT_IRQ_MASK = 6'b01_0011
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [N_ERR-1:0]  err_pulse,
  input logic [N_EVT-1:0]  evt_level,
  input logic [N_IRQ-1:0]  irq_en_q,
  input logic [N_EVT-1:0]  evt_en_q,
  input logic [N_ERR-1:0]  err_status_q,
  input logic [N_IRQ-1:0]  irq_state_q
);
  assert_err_latch_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|err_pulse) |=> ((err_status_q & $past(err_pulse)) == $past(err_pulse)));

  assert_err_clear_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && addr == RA_ERR_STAT && wdata[0] && !err_pulse[0]) |=> !err_status_q[0]);

  assert_evt_fire_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_en_q[IRQ_EVT_BIT] && |(evt_level & evt_en_q & EVT_IRQ_MASK)) |=> irq_state_q[IRQ_EVT_BIT]);

  assert_test_set_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && addr == RA_TEST && wdata[IRQ_EVT_BIT] && irq_en_q[IRQ_EVT_BIT]) |=> irq_state_q[IRQ_EVT_BIT]);

  assert_state_hold_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(irq_state_q[IRQ_ERR_BIT]) |-> $past(wr_en && addr == RA_STATE && wdata[IRQ_ERR_BIT]));
endmodule

bind spih_irq_hub spih_irq_hub_chk #(
  .DATA_W       (DATA_W),
  .N_ERR        (N_ERR),
  .N_EVT        (N_EVT),
  .EVT_IRQ_MASK (EVT_IRQ_MASK)
) u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .wr_en        (wr_en),
  .addr         (addr),
  .wdata        (wdata),
  .err_pulse    (err_pulse),
  .evt_level    (evt_level),
  .irq_en_q     (irq_en_q),
  .evt_en_q     (evt_en_q),
  .err_status_q (err_status_q),
  .irq_state_q  (irq_state_q)
);

// File: tb/spih_irq_hub_test.sv
`timescale 1ns/1ps
module spih_irq_hub_test;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [5:0]  err_pulse;
  logic [5:0]  evt_level;
  logic        irq_err;
  logic        irq_evt;

  int checks   = 0;
  int failures = 0;

  localparam logic [2:0] A_STATE = 3'd0, A_ENABLE = 3'd1, A_TEST = 3'd2,
                         A_ERR_EN = 3'd3, A_ERR_STAT = 3'd4, A_EVT_EN = 3'd5;

  spih_irq_hub uut (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .addr (addr), .wdata (wdata),
    .rdata (rdata), .err_pulse (err_pulse), .evt_level (evt_level),
    .irq_err (irq_err), .irq_evt (irq_evt)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 3'd0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
    addr = 3'd0;
  endtask

  task automatic pulse(input logic [5:0] p);
    @(negedge clk);
    err_pulse = p;
    @(negedge clk);
    err_pulse = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_STATE, v);    check("R1 state", v, 32'h0);
    rd(A_ENABLE, v);   check("R1 enable", v, 32'h0);
    rd(A_TEST, v);     check("R1 test", v, 32'h0);
    rd(A_ERR_EN, v);   check("R1 err_en", v, 32'h1F);
    rd(A_ERR_STAT, v); check("R1 err_stat", v, 32'h0);
    rd(A_EVT_EN, v);   check("R1 evt_en", v, 32'h0);
    check("R1 irq_err", {31'b0, irq_err}, 32'h0);
    check("R1 irq_evt", {31'b0, irq_evt}, 32'h0);
  endtask

  task automatic t_err_latch();
    logic [31:0] v;
    pulse(6'h02);
    rd(A_ERR_STAT, v); check("R2 overflow latched", v, 32'h02);
    pulse(6'h20);
    rd(A_ERR_STAT, v); check("R2 second cause latched", v, 32'h22);
    wr(A_ERR_STAT, 32'h02);
    rd(A_ERR_STAT, v); check("R3 w1c clears one bit", v, 32'h20);
    @(negedge clk);
    wr_en = 1'b1; addr = A_ERR_STAT; wdata = 32'h20; err_pulse = 6'h20;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0; err_pulse = '0;
    rd(A_ERR_STAT, v); check("R2 pulse beats clear", v, 32'h20);
    wr(A_ERR_STAT, 32'h3F);
    rd(A_ERR_STAT, v); check("R3 clear all", v, 32'h0);
    check("R9 no irq while disabled", {31'b0, irq_err}, 32'h0);
  endtask

  task automatic t_err_irq();
    logic [31:0] v;
    wr(A_ENABLE, 32'h1);
    pulse(6'h04);
    tick();
    check("R4 underflow raises irq_err", {31'b0, irq_err}, 32'h1);
    rd(A_STATE, v); check("R4 state bit0", v, 32'h1);
    wr(A_STATE, 32'h1);
    rd(A_STATE, v); check("R8 clear overridden by active cause", v, 32'h1);
    wr(A_ERR_STAT, 32'h04);
    wr(A_STATE, 32'h1);
    rd(A_STATE, v); check("R8 state cleared", v, 32'h0);
    check("R8 irq_err dropped", {31'b0, irq_err}, 32'h0);
    wr(A_ERR_EN, 32'h1B);
    pulse(6'h04);
    tick();
    check("R4 masked cause no irq", {31'b0, irq_err}, 32'h0);
    rd(A_STATE, v); check("R4 masked cause no state", v, 32'h0);
    wr(A_ERR_STAT, 32'h04);
    wr(A_ERR_EN, 32'h1F);
  endtask

  task automatic t_access_invalid();
    logic [31:0] v;
    pulse(6'h20);
    tick(); tick();
    check("R5 access bit no irq", {31'b0, irq_err}, 32'h0);
    rd(A_ERR_STAT, v); check("R5 access bit latched", v, 32'h20);
    wr(A_ERR_STAT, 32'h20);
    wr(A_ENABLE, 32'h0);
  endtask

  task automatic t_evt();
    logic [31:0] v;
    wr(A_ENABLE, 32'h2);
    wr(A_EVT_EN, 32'h3F);
    evt_level = 6'h2C;
    tick(); tick();
    check("R6 watermark/idle ignored", {31'b0, irq_evt}, 32'h0);
    rd(A_STATE, v); check("R6 watermark/idle no state", v, 32'h0);
    evt_level = 6'h02;
    tick();
    check("R6 tx empty raises irq_evt", {31'b0, irq_evt}, 32'h1);
    evt_level = 6'h00;
    wr(A_STATE, 32'h2);
    check("R8 event cleared", {31'b0, irq_evt}, 32'h0);
    evt_level = 6'h10;
    tick();
    check("R6 ready raises irq_evt", {31'b0, irq_evt}, 32'h1);
    evt_level = 6'h00;
    wr(A_STATE, 32'h2);
    wr(A_EVT_EN, 32'h3E);
    evt_level = 6'h01;
    tick(); tick();
    check("R6 rx full disabled", {31'b0, irq_evt}, 32'h0);
    wr(A_EVT_EN, 32'h3F);
    tick();
    check("R6 rx full enabled", {31'b0, irq_evt}, 32'h1);
    evt_level = 6'h00;
    wr(A_STATE, 32'h2);
    wr(A_EVT_EN, 32'h0);
    wr(A_ENABLE, 32'h0);
  endtask

  task automatic t_test();
    logic [31:0] v;
    wr(A_ENABLE, 32'h3);
    wr(A_TEST, 32'h1);
    check("R7 test err", {30'b0, irq_evt, irq_err}, 32'h1);
    rd(A_TEST, v); check("R7 test reads zero", v, 32'h0);
    wr(A_TEST, 32'h2);
    check("R7 test evt", {30'b0, irq_evt, irq_err}, 32'h3);
    wr(A_STATE, 32'h3);
    check("R8 both cleared", {30'b0, irq_evt, irq_err}, 32'h0);
    wr(A_ENABLE, 32'h0);
    wr(A_TEST, 32'h3);
    rd(A_STATE, v); check("R7 test ignored when disabled", v, 32'h0);
  endtask

  task automatic t_gate();
    logic [31:0] v;
    wr(A_ENABLE, 32'h1);
    wr(A_TEST, 32'h1);
    check("R9 line high", {31'b0, irq_err}, 32'h1);
    wr(A_ENABLE, 32'h0);
    check("R9 line gated low", {31'b0, irq_err}, 32'h0);
    rd(A_STATE, v); check("R9 state kept", v, 32'h1);
    wr(A_ENABLE, 32'h1);
    check("R9 line back high", {31'b0, irq_err}, 32'h1);
    wr(A_STATE, 32'h1);
    check("R8 line cleared", {31'b0, irq_err}, 32'h0);
    wr(A_ENABLE, 32'h0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    wr(A_EVT_EN, 32'hFFFF_FFFF);
    rd(A_EVT_EN, v); check("R10 evt_en width", v, 32'h3F);
    wr(A_ENABLE, 32'hFFFF_FFFC);
    rd(A_ENABLE, v); check("R10 enable width", v, 32'h0);
    wr(3'd6, 32'hFF);
    wr(3'd7, 32'hFF);
    rd(3'd6, v); check("R10 addr6 zero", v, 32'h0);
    rd(3'd7, v); check("R10 addr7 zero", v, 32'h0);
    rd(A_ERR_EN, v); check("R10 unmapped write no effect", v, 32'h1F);
    rd(A_STATE, v); check("R10 state untouched", v, 32'h0);
    wr(A_EVT_EN, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    err_pulse = '0; evt_level = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_err_latch();
    t_err_irq();
    t_access_invalid();
    t_evt();
    t_test();
    t_gate();
    t_map();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule